// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This unit orders two IEEE-754 binary64 operands. It returns a one-hot condition code with four bits: less, greater, equal and unordered. It also reports two invalid-operation conditions. The first is a signalling-NaN flag. The second is an invalid-compare flag, used by the ordered flavour of the compare when a NaN is present.

The caller presents both operands together with two control bits. One bit selects ordered or unordered mode, and the other is the invalid-operation enable. The caller then pulses a valid strobe. One clock later the result appears on registered outputs along with a one-cycle done pulse.

The ordering is worked out from each operand's sign, class and magnitude field. No subtractor is involved. The code and flags keep their values until the next compare is issued.

Top module: `fpcmp_unit`

## Requirements
- R1: When either operand is a NaN (exponent all ones, fraction nonzero), the code is unordered. The code uses bit 3 for less, bit 2 for greater, bit 1 for equal and bit 0 for unordered, so an unordered result is 4'b0001.
- R2: The signalling-NaN flag is set when either operand is a NaN whose fraction bit 51 is 0. This holds in both modes. The flag is 0 for any other operand pair.
- R3: The invalid-compare flag is set only in ordered mode (mode bit 1) and only when a NaN is present. It is set when the enable bit is 1 or when either operand is a quiet NaN (fraction bit 51 set). In unordered mode the flag is always 0.
- R4: Two zeros give equal, whatever their signs.
- R5: If the operands have different signs and are not both zero, the negative operand is the lesser one. The code is less when A is negative and greater when B is negative.
- R6: When the signs are equal, a difference in class decides the order, with zero < finite < infinity by magnitude.
- R7: When both operands are negative, the magnitude verdict is reversed. The smaller magnitude gives greater.
- R8: Two infinities with the same sign give equal.
- R9: Finite operands, subnormals included, are ordered by the unsigned 63-bit exponent-and-fraction field. They are equal only when that field is identical.
- R10: The outputs update one cycle after the valid strobe. Done is high for exactly that cycle. The code and flags keep their values while no compare is issued.
- R11: A synchronous reset clears the code, both flags and done to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts a compare of the current inputs |
| op_a | input | 64 | Operand A, binary64 |
| op_b | input | 64 | Operand B, binary64 |
| ordered_mode | input | 1 | 1 = ordered compare, 0 = unordered compare |
| inv_enable | input | 1 | Invalid-operation enable |
| cc_out | output | 4 | One-hot code {less, greater, equal, unordered} |
| snan_flag | output | 1 | Signalling-NaN invalid flag |
| invcmp_flag | output | 1 | Invalid-compare flag |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench compares +0 with -0. A design that checks the sign first returns less or greater for this pair. Pairs of negative operands in each class catch a missing mirror, which would report -2 as greater than -1. Subnormal against normal inputs catch an exponent-only compare, and equal infinities catch an infinity pair wrongly reported as unordered. The NaN cases sweep mode, quietness and the enable bit, so a design that raises the invalid-compare flag in unordered mode is caught. A design that ignores the enable when only a signalling NaN is present is caught the same way.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int DATA_W = 1 + MAG_W;
    localparam int CC_W   = 4;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_FIN  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef struct packed {
        logic             sign;
        cls_e             cls;
        logic             quiet;
        logic [MAG_W-1:0] mag;
    } opinfo_t;

    typedef struct packed {
        logic [CC_W-1:0] cc;
        logic            snan;
        logic            invcmp;
    } verdict_t;

    localparam logic [CC_W-1:0] CC_LT = 4'b1000;
    localparam logic [CC_W-1:0] CC_GT = 4'b0100;
    localparam logic [CC_W-1:0] CC_EQ = 4'b0010;
    localparam logic [CC_W-1:0] CC_UN = 4'b0001;

    // Reverses a magnitude verdict when both operands are negative.
    function automatic logic [CC_W-1:0] signed_order(input logic neg,
                                                     input logic [CC_W-1:0] c);
        if (!neg)          return c;
        else if (c == CC_LT) return CC_GT;
        else if (c == CC_GT) return CC_LT;
        else               return c;
    endfunction
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] bits,
    output opinfo_t        info
);
    logic [EW-1:0] expo;
    logic [FW-1:0] frac;

    assign expo = bits[EW+FW-1 -: EW];
    assign frac = bits[FW-1:0];

    always_comb begin
        info.sign  = bits[EW+FW];
        info.quiet = frac[FW-1];
        info.mag   = bits[EW+FW-1:0];
        if (&expo)
            info.cls = (frac != '0) ? CLS_NAN : CLS_INF;
        else if (expo == '0 && frac == '0)
            info.cls = CLS_ZERO;
        else
            info.cls = CLS_FIN;
    end
endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
    import fpcmp_pkg::*;
(
    input  opinfo_t  a,
    input  opinfo_t  b,
    input  logic     ordered,
    input  logic     inv_en,
    output verdict_t v
);
    logic a_nan, b_nan;
    logic [CC_W-1:0] mag_cc;

    assign a_nan = (a.cls == CLS_NAN);
    assign b_nan = (b.cls == CLS_NAN);

    // Magnitude verdict for operands of the same sign.
    always_comb begin
        if (a.cls < b.cls)            mag_cc = CC_LT;
        else if (a.cls > b.cls)       mag_cc = CC_GT;
        else if (a.cls == CLS_INF)    mag_cc = CC_EQ;
        else if (a.mag < b.mag)       mag_cc = CC_LT;
        else if (a.mag > b.mag)       mag_cc = CC_GT;
        else                          mag_cc = CC_EQ;
    end

    always_comb begin
        v = '0;
        if (a_nan || b_nan) begin
            v.cc     = CC_UN;
            v.snan   = (a_nan && !a.quiet) || (b_nan && !b.quiet);
            v.invcmp = ordered && (inv_en || (a_nan && a.quiet) || (b_nan && b.quiet));
        end else if (a.cls == CLS_ZERO && b.cls == CLS_ZERO) begin
            v.cc = CC_EQ;
        end else if (a.sign != b.sign) begin
            v.cc = a.sign ? CC_LT : CC_GT;
        end else begin
            v.cc = signed_order(a.sign, mag_cc);
        end
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              ordered_mode,
    input  logic              inv_enable,
    output logic [CC_W-1:0]   cc_out,
    output logic              snan_flag,
    output logic              invcmp_flag,
    output logic              done
);
    localparam int N_OPS = 2;

    logic [DATA_W-1:0] ops   [N_OPS];
    opinfo_t           infos [N_OPS];
    verdict_t          verdict;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fpcmp_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
            .bits (ops[i]),
            .info (infos[i])
        );
    end

    fpcmp_decide u_dec (
        .a       (infos[0]),
        .b       (infos[1]),
        .ordered (ordered_mode),
        .inv_en  (inv_enable),
        .v       (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_out      <= '0;
            snan_flag   <= 1'b0;
            invcmp_flag <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                cc_out      <= verdict.cc;
                snan_flag   <= verdict.snan;
                invcmp_flag <= verdict.invcmp;
            end
        end
    end

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);                                              // R10
    AST_DONE_ONLY_PULSE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);                                            // R10
    AST_CC_HELD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cc_out));                                  // R10
    AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones(cc_out) == 1));                             // R1
    AST_SNAN_IS_UNORD: assert property (@(posedge clk) disable iff (rst)
        snan_flag |-> (cc_out == CC_UN));                                // R2
    AST_UNORD_NO_INV: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ordered_mode) |=> !invcmp_flag);                   // R3
    AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a[DATA_W-2:0] == '0 && op_b[DATA_W-2:0] == '0)
        |=> (cc_out == CC_EQ));                                          // R4
endmodule

// File: tb/fpcmp_unit_test.sv
module fpcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        ordered_mode = 1'b0, inv_enable = 1'b0;
    logic [3:0]  cc_out;
    logic        snan_flag, invcmp_flag, done;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [3:0] cc;
        logic       sn;
        logic       inv;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    logic [3:0] last_cc = '0;

    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SUB1 = 64'h0000_0000_0000_0001;
    localparam logic [63:0] SUBM = 64'h000F_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h0010_0000_0000_0000;

    fpcmp_unit uut (
        .clk, .rst, .in_valid, .op_a, .op_b, .ordered_mode, .inv_enable,
        .cc_out, .snan_flag, .invcmp_flag, .done
    );

    always #10 clk = ~clk;

    function automatic logic is_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != '0);
    endfunction

    // Monotone key: larger key means larger value; both zeros share one key.
    function automatic logic [63:0] order_key(input logic [63:0] x);
        if (x[62:0] == '0) return 64'h8000_0000_0000_0000;
        if (x[63])         return ~x;
        return x | 64'h8000_0000_0000_0000;
    endfunction

    function automatic exp_t model(input logic [63:0] a, b, input logic ord, en,
                                   input string tag);
        exp_t e;
        e.tag = tag; e.sn = 1'b0; e.inv = 1'b0;
        if (is_nan(a) || is_nan(b)) begin
            e.cc  = 4'b0001;
            e.sn  = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
            e.inv = ord && (en || (is_nan(a) && a[51]) || (is_nan(b) && b[51]));
        end else if (order_key(a) < order_key(b)) e.cc = 4'b1000;
        else if (order_key(a) > order_key(b))     e.cc = 4'b0100;
        else                                      e.cc = 4'b0010;
        return e;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic issue(input logic [63:0] a, b, input logic ord, en, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; ordered_mode = ord; inv_enable = en; in_valid = 1'b1;
        sbq.push_back(model(a, b, ord, en, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on every done.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10", "done without compare", {7'd0, done}, 8'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(cc_out == e.cc, e.tag, "cc", {4'd0, cc_out}, {4'd0, e.cc});
                check(snan_flag == e.sn, e.tag, "snan", {7'd0, snan_flag}, {7'd0, e.sn});
                check(invcmp_flag == e.inv, e.tag, "invcmp", {7'd0, invcmp_flag}, {7'd0, e.inv});
                last_cc = e.cc;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", sbq.size());
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({cc_out, snan_flag, invcmp_flag, done} == 7'd0, "R11", "reset state",
              {1'b0, cc_out, snan_flag, invcmp_flag, done}, 8'd0);
        rst = 1'b0;

        issue(PZ, NZ, 1, 0, "R4");            idle(1);
        issue(NZ, PZ, 0, 0, "R4");            idle(1);
        issue(NONE, ONE, 1, 0, "R5");         idle(1);
        issue(TWO, NTWO, 1, 0, "R5");         idle(1);
        issue(NZ, ONE, 0, 0, "R5");           idle(1);
        issue(PZ, ONE, 0, 0, "R6");           idle(1);
        issue(PINF, TWO, 0, 0, "R6");         idle(1);
        issue(NONE, NTWO, 1, 0, "R7");        idle(1);
        issue(NINF, NONE, 1, 0, "R7");        idle(1);
        issue(NZ, NTWO, 1, 0, "R7");          idle(1);
        issue(PINF, PINF, 1, 0, "R8");        idle(1);
        issue(NINF, NINF, 0, 0, "R8");        idle(1);
        issue(SUB1, MINN, 0, 0, "R9");        idle(1);
        issue(SUBM, SUB1, 0, 0, "R9");        idle(1);
        issue(TWO, TWO, 0, 0, "R9");          idle(1);
        issue(ONE, TWO, 0, 0, "R9");          idle(1);
        issue(QNAN, ONE, 0, 0, "R1");         idle(1);
        issue(QNAN, ONE, 1, 0, "R3");         idle(1);
        issue(ONE, QNAN, 0, 1, "R3");         idle(1);
        issue(SNAN, ONE, 1, 0, "R2");         idle(1);
        issue(SNAN, ONE, 1, 1, "R3");         idle(1);
        issue(ONE, SNAN, 0, 1, "R2");         idle(1);
        issue(SNAN, QNAN, 1, 0, "R2");        idle(1);
        // back-to-back compares
        issue(ONE, TWO, 0, 0, "R10");
        issue(TWO, ONE, 0, 0, "R10");
        issue(NONE, NONE, 0, 0, "R10");
        idle(4);
        check(done == 1'b0, "R10", "done stays low when idle", {7'd0, done}, 8'd0);
        check(cc_out == last_cc, "R10", "cc held while idle", {4'd0, cc_out}, {4'd0, last_cc});
        check(sbq.size() == 0, "R10", "all results seen", sbq.size[7:0], 8'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule